// File: doc/BRIEF.md
# DCC Function Command Decoder

This block sits behind a DCC bit-stream receiver that has already framed a packet. It takes the first three bytes of that packet, the number of bytes received (two to four, error byte included) and a flag raised by the receiver when the packet is bad. From this it works out which address format is in use and pulls out the address and the instruction byte. It compares the address with a decoder address supplied on a configuration input.

When the address matches, the instruction updates one of three function groups or the direction of travel. The stored state is presented as a 13-bit function vector (F0 to F12) and a forward flag. Downstream logic, such as lamp drivers, uses these to pick which outputs to light. Decoding is combinational. The state registers load on the same clock edge that samples the packet strobe.

Top module: `fn_cmd_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, `func_out` is all zero and `fwd_out` is 0 (reverse). Asserting `rst_n` clears the state asynchronously, mid-operation included.
- R2: When bits 7:6 of byte 0 are not both 1, the address is byte 0 zero-extended to 14 bits and the instruction is byte 1. Byte i sits on `pkt_head[8i+7:8i]`.
- R3: When bits 7:6 of byte 0 are both 1, the address is {byte0[5:0], byte1} and the instruction is byte 2. All-ones bytes give address 0x3FFF.
- R4: Instruction bits 7:5 = 100 loads `func_out[0]` (F0) from bit 4 and `func_out[4:1]` (F4..F1) from bits 3:0. All other state is left unchanged.
- R5: Instruction bits 7:5 = 101 with bit 4 = 1 loads `func_out[8:5]` (F8..F5) from bits 3:0. All other state is left unchanged.
- R6: Instruction bits 7:5 = 101 with bit 4 = 0 loads `func_out[12:9]` (F12..F9) from bits 3:0. All other state is left unchanged.
- R7: Instruction bits 7:5 = 010 sets `fwd_out` to 0, and 011 sets it to 1. The function vector is left unchanged.
- R8: A packet whose extracted address differs from `cfg_addr` changes no state.
- R9: A packet strobed with `pkt_bad` = 1 changes no state.
- R10: Instructions with bits 7:5 equal to 000, 001, 110 or 111 change no state. At most one of the four update kinds happens per packet.
- R11: State changes only on a rising clock edge where `pkt_valid` = 1. The new value is visible right after that edge, and the state holds in every other cycle.
- R12: A packet is discarded when `pkt_nbytes` is below 2 in the short format, below 3 in the long format, or above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_valid | input | 1 | One-cycle strobe: a framed packet is present |
| pkt_bad | input | 1 | Receiver marks the strobed packet as corrupt |
| pkt_head | input | 24 | Bytes 0..2 of the packet, byte i on bits 8i+7:8i |
| pkt_nbytes | input | 3 | Number of bytes in the packet |
| cfg_addr | input | 14 | Decoder address to respond to |
| func_out | output | 13 | Function state, bit n = Fn |
| fwd_out | output | 1 | 1 = forward, 0 = reverse |

## Verification
Two functions can meet on one edge: an accepted update and a veto. The veto comes from the bad-packet flag, a length outside the legal range, or an address mismatch. The bench raises the strobe together with each veto, using instructions that would otherwise change the state, and checks that the outputs after that edge still hold the previous values. It also strobes a high-nibble and a low-nibble update on back-to-back edges and checks that both land without disturbing each other. In addition, it checks before the edge that the strobe alone has not changed the outputs.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 14;
  localparam int FN_W     = 13;
  localparam int NIB_W    = 4;
  localparam int GRP1_W   = NIB_W + 1;
  localparam int LO_BASE  = GRP1_W;
  localparam int HI_BASE  = LO_BASE + NIB_W;
  localparam int OPC_W    = 3;

  localparam logic [OPC_W-1:0] OPC_REV  = 3'b010;
  localparam logic [OPC_W-1:0] OPC_FWD  = 3'b011;
  localparam logic [OPC_W-1:0] OPC_GRP1 = 3'b100;
  localparam logic [OPC_W-1:0] OPC_GRP2 = 3'b101;

  typedef struct packed {
    logic grp1;
    logic nib_lo;
    logic nib_hi;
    logic dir;
  } fcd_wr_t;
endpackage

// File: rtl/fcd_reset_sync.sv
module fcd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fcd_addr_extract.sv
module fcd_addr_extract
  import fcd_pkg::*;
#(
  parameter int HEAD_BYTES = 3,
  parameter int MAX_BYTES  = 4,
  parameter int CNT_W      = 3
) (
  input  logic [HEAD_BYTES*BYTE_W-1:0] pkt_head,
  input  logic [CNT_W-1:0]             pkt_nbytes,
  output logic [ADDR_W-1:0]            addr,
  output logic [BYTE_W-1:0]            instr,
  output logic                         len_ok
);
  localparam int HI_ADDR_W = ADDR_W - BYTE_W;
  localparam logic [CNT_W-1:0] MIN_SHORT = CNT_W'(2);
  localparam logic [CNT_W-1:0] MIN_LONG  = CNT_W'(3);
  localparam logic [CNT_W-1:0] MAX_CNT   = CNT_W'(MAX_BYTES);

  logic [BYTE_W-1:0] byte_q [HEAD_BYTES];
  logic              long_fmt;

  for (genvar i = 0; i < HEAD_BYTES; i++) begin : g_split
    assign byte_q[i] = pkt_head[i*BYTE_W +: BYTE_W];
  end

  assign long_fmt = &byte_q[0][BYTE_W-1:BYTE_W-2];

  always_comb begin
    if (long_fmt) begin
      addr   = {byte_q[0][HI_ADDR_W-1:0], byte_q[1]};
      instr  = byte_q[2];
      len_ok = (pkt_nbytes >= MIN_LONG) && (pkt_nbytes <= MAX_CNT);
    end else begin
      addr   = {{HI_ADDR_W{1'b0}}, byte_q[0]};
      instr  = byte_q[1];
      len_ok = (pkt_nbytes >= MIN_SHORT) && (pkt_nbytes <= MAX_CNT);
    end
  end
endmodule

// File: rtl/fcd_instr_decode.sv
module fcd_instr_decode
  import fcd_pkg::*;
(
  input  logic              accept,
  input  logic [BYTE_W-1:0] instr,
  output fcd_wr_t           wr,
  output logic [NIB_W-1:0]  nib,
  output logic              f0_bit,
  output logic              dir_fwd
);
  logic [OPC_W-1:0] opc;

  assign opc     = instr[BYTE_W-1 -: OPC_W];
  assign nib     = instr[NIB_W-1:0];
  assign f0_bit  = instr[NIB_W];
  assign dir_fwd = instr[BYTE_W-OPC_W];

  always_comb begin
    wr = '0;
    if (accept) begin
      unique case (opc)
        OPC_GRP1: wr.grp1 = 1'b1;
        OPC_GRP2: begin
          if (instr[NIB_W]) wr.nib_lo = 1'b1;
          else              wr.nib_hi = 1'b1;
        end
        OPC_REV, OPC_FWD: wr.dir = 1'b1;
        default: wr = '0;
      endcase
    end
  end
endmodule

// File: rtl/fcd_state_regs.sv
module fcd_state_regs
  import fcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  fcd_wr_t          wr,
  input  logic [NIB_W-1:0] nib,
  input  logic             f0_bit,
  input  logic             dir_fwd,
  output logic [FN_W-1:0]  func_q,
  output logic             fwd_q
);
  logic [FN_W-1:0] func_d;
  logic            fwd_d;
  logic            upd_en;

  assign upd_en = wr.grp1 | wr.nib_lo | wr.nib_hi | wr.dir;

  always_comb begin
    func_d = func_q;
    fwd_d  = fwd_q;
    if (wr.grp1)   func_d[GRP1_W-1:0]            = {nib, f0_bit};
    if (wr.nib_lo) func_d[LO_BASE +: NIB_W]      = nib;
    if (wr.nib_hi) func_d[HI_BASE +: NIB_W]      = nib;
    if (wr.dir)    fwd_d                         = dir_fwd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      fwd_q  <= 1'b0;
    end else if (upd_en) begin
      func_q <= func_d;
      fwd_q  <= fwd_d;
    end
  end
endmodule

// File: rtl/fn_cmd_decoder.sv
module fn_cmd_decoder
  import fcd_pkg::*;
#(
  parameter  int MAX_BYTES  = 4,
  parameter  int HEAD_BYTES = 3,
  localparam int CNT_W      = $clog2(MAX_BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pkt_valid,
  input  logic                         pkt_bad,
  input  logic [HEAD_BYTES*BYTE_W-1:0] pkt_head,
  input  logic [CNT_W-1:0]             pkt_nbytes,
  input  logic [ADDR_W-1:0]            cfg_addr,
  output logic [FN_W-1:0]              func_out,
  output logic                         fwd_out
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] pkt_addr;
  logic [BYTE_W-1:0] pkt_instr;
  logic              len_ok;
  logic              accept;
  fcd_wr_t           wr_en;
  logic [NIB_W-1:0]  nib;
  logic              f0_bit;
  logic              dir_fwd;

  fcd_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fcd_addr_extract #(
    .HEAD_BYTES (HEAD_BYTES),
    .MAX_BYTES  (MAX_BYTES),
    .CNT_W      (CNT_W)
  ) u_extract (
    .pkt_head   (pkt_head),
    .pkt_nbytes (pkt_nbytes),
    .addr       (pkt_addr),
    .instr      (pkt_instr),
    .len_ok     (len_ok)
  );

  assign accept = pkt_valid & ~pkt_bad & len_ok & (pkt_addr == cfg_addr);

  fcd_instr_decode u_decode (
    .accept  (accept),
    .instr   (pkt_instr),
    .wr      (wr_en),
    .nib     (nib),
    .f0_bit  (f0_bit),
    .dir_fwd (dir_fwd)
  );

  fcd_state_regs u_state (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (wr_en),
    .nib     (nib),
    .f0_bit  (f0_bit),
    .dir_fwd (dir_fwd),
    .func_q  (func_out),
    .fwd_q   (fwd_out)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic             pkt_bad,
  input fcd_wr_t          wr,
  input logic [NIB_W-1:0] nib,
  input logic [FN_W-1:0]  func_out,
  input logic             fwd_out
);
  // R11
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> ($stable(func_out) && $stable(fwd_out)));

  // R9
  bad_pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_bad) |=> ($stable(func_out) && $stable(fwd_out)));

  // R4
  grp1_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr.grp1 |=> ($stable(func_out[FN_W-1:GRP1_W]) && $stable(fwd_out)));

  // R5
  nib_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr.nib_lo |=> ((func_out[LO_BASE +: NIB_W] == $past(nib)) &&
                   $stable(func_out[HI_BASE +: NIB_W]) &&
                   $stable(func_out[GRP1_W-1:0]) && $stable(fwd_out)));

  // R6
  nib_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr.nib_hi |=> ((func_out[HI_BASE +: NIB_W] == $past(nib)) &&
                   $stable(func_out[HI_BASE-1:0]) && $stable(fwd_out)));

  // R7
  dir_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr.dir |=> $stable(func_out));

  // R10
  single_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr.grp1, wr.nib_lo, wr.nib_hi, wr.dir}));
endmodule

bind fn_cmd_decoder fcd_checker u_fcd_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .pkt_valid (pkt_valid),
  .pkt_bad   (pkt_bad),
  .wr        (wr_en),
  .nib       (nib),
  .func_out  (func_out),
  .fwd_out   (fwd_out)
);

// File: tb/tb_fn_cmd_decoder.sv
`timescale 1ns/1ps
module tb_fn_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pkt_valid;
  logic        pkt_bad;
  logic [23:0] pkt_head;
  logic [2:0]  pkt_nbytes;
  logic [13:0] cfg_addr;
  logic [12:0] func_out;
  logic        fwd_out;

  int n_checks = 0;
  int n_err    = 0;

  always #2 clk = ~clk;

  fn_cmd_decoder dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_valid  (pkt_valid),
    .pkt_bad    (pkt_bad),
    .pkt_head   (pkt_head),
    .pkt_nbytes (pkt_nbytes),
    .cfg_addr   (cfg_addr),
    .func_out   (func_out),
    .fwd_out    (fwd_out)
  );

  // Fields: [65:63] nbytes, [62] bad, [61:38] head {b2,b1,b0},
  // [37:25] expected func, [24] expected fwd, [23:0] requirement tag
  localparam int NV = 18;
  localparam logic [65:0] VEC [NV] = '{
    {3'd3, 1'b0, 24'h009F03, 13'h001F, 1'b0, "R4 "},
    {3'd3, 1'b0, 24'h00BA03, 13'h015F, 1'b0, "R5 "},
    {3'd3, 1'b0, 24'h00A503, 13'h0B5F, 1'b0, "R6 "},
    {3'd3, 1'b0, 24'h006003, 13'h0B5F, 1'b1, "R7 "},
    {3'd3, 1'b0, 24'h008004, 13'h0B5F, 1'b1, "R8 "},
    {3'd3, 1'b1, 24'h008003, 13'h0B5F, 1'b1, "R9 "},
    {3'd4, 1'b0, 24'h8003C0, 13'h0B40, 1'b1, "R3 "},
    {3'd2, 1'b0, 24'h9103C0, 13'h0B40, 1'b1, "R12"},
    {3'd3, 1'b0, 24'h9103C0, 13'h0B43, 1'b1, "R3 "},
    {3'd2, 1'b0, 24'h004003, 13'h0B43, 1'b0, "R7 "},
    {3'd3, 1'b0, 24'h003F03, 13'h0B43, 1'b0, "R10"},
    {3'd3, 1'b0, 24'h00E503, 13'h0B43, 1'b0, "R10"},
    {3'd3, 1'b0, 24'h00B003, 13'h0A03, 1'b0, "R5 "},
    {3'd3, 1'b0, 24'h009F83, 13'h0A03, 1'b0, "R2 "},
    {3'd5, 1'b0, 24'h009F03, 13'h0A03, 1'b0, "R12"},
    {3'd1, 1'b0, 24'h009F03, 13'h0A03, 1'b0, "R12"},
    {3'd3, 1'b0, 24'h9F03C1, 13'h0A03, 1'b0, "R8 "},
    {3'd2, 1'b0, 24'h009F03, 13'h0A1F, 1'b0, "R2 "}
  };

  task automatic chk_func(input string req, input logic [12:0] exp);
    n_checks++;
    if (func_out !== exp) begin
      n_err++;
      $display("FAIL %s: func_out=%h expected %h", req, func_out, exp);
    end
  endtask

  task automatic chk_fwd(input string req, input logic exp);
    n_checks++;
    if (fwd_out !== exp) begin
      n_err++;
      $display("FAIL %s: fwd_out=%b expected %b", req, fwd_out, exp);
    end
  endtask

  task automatic send(input logic [2:0] nb, input logic bad, input logic [23:0] hd);
    @(negedge clk);
    pkt_valid  = 1'b1;
    pkt_bad    = bad;
    pkt_nbytes = nb;
    pkt_head   = hd;
    @(negedge clk);
    pkt_valid  = 1'b0;
    pkt_bad    = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_func("R1", 13'h0000);
    chk_fwd("R1", 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    pkt_valid  = 1'b0;
    pkt_bad    = 1'b0;
    pkt_head   = '0;
    pkt_nbytes = '0;
    cfg_addr   = 14'd3;

    // R1: reset state during and after reset
    do_reset();
    chk_func("R1", 13'h0000);
    chk_fwd("R1", 1'b0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [65:0] v;
      string tag;
      v = VEC[i];
      send(v[65:63], v[62], v[61:38]);
      tag = $sformatf("%s", v[23:0]);
      chk_func(tag, v[37:25]);
      chk_fwd(tag, v[24]);
    end

    // R11: matching packet on the inputs with no strobe changes nothing
    @(negedge clk);
    pkt_nbytes = 3'd3;
    pkt_head   = 24'h00BF03;
    repeat (2) @(negedge clk);
    chk_func("R11", 13'h0A1F);

    // R11: strobe alone has no effect before the edge, takes effect after it
    @(negedge clk);
    pkt_valid = 1'b1;
    pkt_head  = 24'h00A303;
    #1;
    chk_func("R11", 13'h0A1F);
    @(negedge clk);
    // back-to-back strobes: high nibble then low nibble (R6, R5)
    pkt_head = 24'h00BC03;
    chk_func("R6", 13'h061F);
    @(negedge clk);
    pkt_valid = 1'b0;
    chk_func("R5", 13'h079F);

    // R3: long address at the top of its range
    cfg_addr = 14'h3FFF;
    send(3'd3, 1'b0, 24'h80FFFF);
    chk_func("R3", 13'h0780);
    // R8: old short address no longer matches
    send(3'd3, 1'b0, 24'h009F03);
    chk_func("R8", 13'h0780);
    send(3'd4, 1'b0, 24'h60FFFF);
    chk_fwd("R7", 1'b1);

    // R1: asynchronous reset mid-operation
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    chk_func("R1", 13'h0000);
    chk_fwd("R1", 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_func("R1", 13'h0000);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule